// File: doc/BRIEF.md
# Single-Wire Monitor Serial Port

This block is the character-level link between a debug monitor core and a host that shares one open-drain data wire with it. Characters are 8-bit NRZ frames: one low start bit, eight data bits with the least significant bit first, and one high stop bit. Transmit and receive use the same bit period. The port is half-duplex. While it sends, and while it answers a break, it does not listen to the wire, so it never decodes its own output.

The bit period is fixed once, on the first mode-entry strobe after reset. It comes from a strap input and an entry-condition input, and it stays in force until the next reset. A break is a frame whose start bit and the nine bit times after it are all low. When the port sees one, it flags it and answers with a fixed sequence: first the wire is left released (high) for two bit times, then a break of its own is sent back. The monitor core moves bytes through a valid/ready transmit handshake and a one-cycle receive strobe.

Top module: `mon_wire_port`

## Requirements
- R1: On the wire, a transmitted byte is a start bit (low), then data bit 0 through bit 7, then a stop bit (high). Each bit lasts exactly one bit period P. The output lineDriveLow=1 pulls the wire low and 0 releases it.
- R2: The receiver samples each bit near its middle, timing from the falling edge of the start bit. When a frame has a high stop bit, the receiver raises rxValid for exactly one cycle and presents the byte on rxData.
- R3: P is DIV_LONG cycles (default 1024) from reset until the first mode-entry strobe. At that strobe P becomes DIV_LONG if strapHigh=1 or altEntry=1, and DIV_SHORT (default 512) if both are 0.
- R4: Mode-entry strobes after the first one have no effect on P until the next reset.
- R5: A start bit followed by nine more low bit periods raises breakDetected for one cycle, with no rxValid.
- R6: After breakDetected, the port keeps the wire released for 2·P cycles, then pulls it low for 10·P cycles, then releases it.
- R7: While a character or the break response is being sent, activity on lineIn produces neither rxValid nor breakDetected.
- R8: txReady is 1 only when the port is idle: not receiving, not transmitting, not responding to a break. A byte is taken on a cycle where txValid and txReady are both 1, and the start bit appears on the next cycle.
- R9: A frame with a low stop bit and nonzero data is dropped without any pulse. The receiver re-arms only after the wire is seen high.
- R10: After reset the wire is released, txReady is 1, and rxValid and breakDetected are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeEnter | input | 1 | Mode-entry strobe that latches the bit period |
| strapHigh | input | 1 | Strap level sampled on mode entry |
| altEntry | input | 1 | Entry condition; 1 forces the long period |
| lineIn | input | 1 | Level seen on the shared data wire |
| lineDriveLow | output | 1 | Open-drain enable; 1 pulls the wire low |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | Transmit request |
| txReady | output | 1 | Port idle, able to take a byte |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle strobe for a good received byte |
| breakDetected | output | 1 | One-cycle strobe for a received break |

## Verification
A byte is taken at the edge where txValid and txReady are both high. Bit k of that frame then drives the wire during cycles k·P to k·P+P−1 after that edge, so the bench compares lineDriveLow with the expected bit in every one of those cycles, not only at mid-bit. lineIn passes through a two-stage synchronizer, so rxValid and breakDetected arrive about P/2 plus two cycles into the final bit period. The bench therefore monitors the whole frame window plus one extra bit time and counts the pulses, instead of sampling one fixed cycle. The break response is timed from the cycle in which breakDetected is seen: the 2·P released cycles and the 10·P low cycles are checked at exact offsets from that cycle.

// File: rtl/mwp_pkg.sv
package mwp_pkg;

  // One-cycle strobes from the control FSM to the datapath
  typedef struct packed {
    logic timerHalf;
    logic timerFull;
    logic bitClr;
    logic bitInc;
    logic rxShift;
    logic txLoadChar;
    logic txLoadBreak;
    logic txShift;
    logic txStop;
  } mwpCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_TXCHAR,
    ST_TXBRK,
    ST_ARM
  } mwpState_t;

  localparam int CHAR_LAST = 9;   // start + 8 data + stop, index of the last bit
  localparam int BRK_LAST  = 11;  // 2 idle gap bits + 10 low bits

endpackage

// File: rtl/mwp_datapath.sv
module mwp_datapath
  import mwp_pkg::*;
#(
  parameter int DIV_LONG  = 1024,
  parameter int DIV_SHORT = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeEnter,
  input  logic       strapHigh,
  input  logic       altEntry,
  input  logic       lineIn,
  input  logic [7:0] txData,
  input  mwpCtrl_t   ctrl,
  output logic       lineSync,
  output logic       timerDone,
  output logic [3:0] bitCnt,
  output logic [7:0] rxByte,
  output logic       rxZero,
  output logic       lineDriveLow
);

  localparam int PW = $clog2(DIV_LONG + 1);
  localparam logic [PW-1:0] LONG_P  = PW'(DIV_LONG);
  localparam logic [PW-1:0] SHORT_P = PW'(DIV_SHORT);

  logic [PW-1:0] periodReg;
  logic          periodLocked;
  logic [PW-1:0] timerCnt;
  logic [1:0]    syncPipe;
  logic [11:0]   txReg;
  logic          txBusy;

  // Bit period latched once on the first mode-entry strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg    <= LONG_P;
      periodLocked <= 1'b0;
    end else if (modeEnter && !periodLocked) begin
      periodReg    <= (strapHigh || altEntry) ? LONG_P : SHORT_P;
      periodLocked <= 1'b1;
    end
  end

  // Two-stage synchronizer on the wire input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= 2'b11;
    else       syncPipe <= {syncPipe[0], lineIn};
  end
  assign lineSync = syncPipe[1];

  // Bit timer: counts down to zero, reloaded by control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               timerCnt <= '0;
    else if (ctrl.timerFull) timerCnt <= periodReg - PW'(1);
    else if (ctrl.timerHalf) timerCnt <= (periodReg >> 1) - PW'(1);
    else if (timerCnt != '0) timerCnt <= timerCnt - PW'(1);
  end
  assign timerDone = (timerCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            bitCnt <= '0;
    else if (ctrl.bitClr) bitCnt <= '0;
    else if (ctrl.bitInc) bitCnt <= bitCnt + 4'd1;
  end

  // Receive shifter, LSB arrives first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxByte <= '0;
    else if (ctrl.rxShift) rxByte <= {lineSync, rxByte[7:1]};
  end
  assign rxZero = (rxByte == 8'h00);

  // Transmit shifter; bit 0 is the level currently on the wire
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg  <= '1;
      txBusy <= 1'b0;
    end else if (ctrl.txLoadChar) begin
      txReg  <= {2'b11, 1'b1, txData, 1'b0};
      txBusy <= 1'b1;
    end else if (ctrl.txLoadBreak) begin
      txReg  <= {10'b0, 2'b11};
      txBusy <= 1'b1;
    end else if (ctrl.txShift) begin
      txReg  <= {1'b1, txReg[11:1]};
    end else if (ctrl.txStop) begin
      txBusy <= 1'b0;
    end
  end
  assign lineDriveLow = txBusy && !txReg[0];

endmodule

// File: rtl/mwp_control.sv
module mwp_control
  import mwp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineSync,
  input  logic       timerDone,
  input  logic [3:0] bitCnt,
  input  logic       rxZero,
  input  logic       txValid,
  output mwpCtrl_t   ctrl,
  output logic       txReady,
  output logic       rxValid,
  output logic       breakDetected
);

  mwpState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctrl          = '0;
    stateNext     = state;
    txReady       = 1'b0;
    rxValid       = 1'b0;
    breakDetected = 1'b0;
    unique case (state)
      ST_IDLE: begin
        txReady = 1'b1;
        if (txValid) begin
          ctrl.txLoadChar = 1'b1;
          ctrl.timerFull  = 1'b1;
          ctrl.bitClr     = 1'b1;
          stateNext       = ST_TXCHAR;
        end else if (!lineSync) begin
          ctrl.timerHalf = 1'b1;
          ctrl.bitClr    = 1'b1;
          stateNext      = ST_RX;
        end
      end
      ST_RX: begin
        if (timerDone) begin
          if (bitCnt == 4'd0) begin
            if (lineSync) stateNext = ST_ARM;   // start bit was a glitch
            else begin
              ctrl.timerFull = 1'b1;
              ctrl.bitInc    = 1'b1;
            end
          end else if (bitCnt < 4'(CHAR_LAST)) begin
            ctrl.rxShift   = 1'b1;
            ctrl.timerFull = 1'b1;
            ctrl.bitInc    = 1'b1;
          end else if (lineSync) begin
            rxValid   = 1'b1;
            stateNext = ST_IDLE;
          end else if (rxZero) begin
            breakDetected    = 1'b1;
            ctrl.txLoadBreak = 1'b1;
            ctrl.timerFull   = 1'b1;
            ctrl.bitClr      = 1'b1;
            stateNext        = ST_TXBRK;
          end else begin
            stateNext = ST_ARM;                 // framing error
          end
        end
      end
      ST_TXCHAR, ST_TXBRK: begin
        if (timerDone) begin
          if (bitCnt == ((state == ST_TXCHAR) ? 4'(CHAR_LAST) : 4'(BRK_LAST))) begin
            ctrl.txStop = 1'b1;
            stateNext   = ST_ARM;
          end else begin
            ctrl.txShift   = 1'b1;
            ctrl.timerFull = 1'b1;
            ctrl.bitInc    = 1'b1;
          end
        end
      end
      ST_ARM: begin
        if (lineSync) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/mon_wire_port.sv
module mon_wire_port
  import mwp_pkg::*;
#(
  parameter int DIV_LONG  = 1024,
  parameter int DIV_SHORT = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeEnter,
  input  logic       strapHigh,
  input  logic       altEntry,
  input  logic       lineIn,
  output logic       lineDriveLow,
  input  logic [7:0] txData,
  input  logic       txValid,
  output logic       txReady,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       breakDetected
);

  mwpCtrl_t   ctrl;
  logic       lineSync;
  logic       timerDone;
  logic [3:0] bitCnt;
  logic       rxZero;

  mwp_datapath #(.DIV_LONG(DIV_LONG), .DIV_SHORT(DIV_SHORT)) u_dp (
    .clk(clk), .rstN(rstN), .modeEnter(modeEnter), .strapHigh(strapHigh),
    .altEntry(altEntry), .lineIn(lineIn), .txData(txData), .ctrl(ctrl),
    .lineSync(lineSync), .timerDone(timerDone), .bitCnt(bitCnt),
    .rxByte(rxData), .rxZero(rxZero), .lineDriveLow(lineDriveLow)
  );

  mwp_control u_ctl (
    .clk(clk), .rstN(rstN), .lineSync(lineSync), .timerDone(timerDone),
    .bitCnt(bitCnt), .rxZero(rxZero), .txValid(txValid), .ctrl(ctrl),
    .txReady(txReady), .rxValid(rxValid), .breakDetected(breakDetected)
  );

endmodule

// File: rtl/mwp_checker.sv
module mwp_checker (
  input logic clk,
  input logic rstN,
  input logic txValid,
  input logic txReady,
  input logic lineDriveLow,
  input logic rxValid,
  input logic breakDetected
);

  assert_accept_starts_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> lineDriveLow);

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    lineDriveLow |-> !txReady);

  assert_pulse_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && breakDetected));

  assert_rx_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_break_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    breakDetected |=> (!lineDriveLow && !txReady));

  assert_quiet_while_driving_R7: assert property (@(posedge clk) disable iff (!rstN)
    lineDriveLow |-> !(rxValid || breakDetected));

endmodule

bind mon_wire_port mwp_checker u_chk (.*);

// File: tb/tb_mon_wire_port.sv
`timescale 1ns/1ps
module tb_mon_wire_port;

  localparam int LP = 16;
  localparam int SP = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN, modeEnter, strapHigh, altEntry, hostLine;
  logic       lineIn, lineDriveLow, txValid, txReady, rxValid, breakDetected;
  logic [7:0] txData, rxData;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  assign lineIn = hostLine & ~lineDriveLow;

  mon_wire_port #(.DIV_LONG(LP), .DIV_SHORT(SP)) dut (
    .clk(clk), .rstN(rstN), .modeEnter(modeEnter), .strapHigh(strapHigh),
    .altEntry(altEntry), .lineIn(lineIn), .lineDriveLow(lineDriveLow),
    .txData(txData), .txValid(txValid), .txReady(txReady), .rxData(rxData),
    .rxValid(rxValid), .breakDetected(breakDetected)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0; modeEnter = 0; strapHigh = 0; altEntry = 0;
    hostLine = 1; txValid = 0; txData = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic enterMode(input bit s, input bit a);
    strapHigh = s; altEntry = a; modeEnter = 1;
    @(negedge clk);
    modeEnter = 0; strapHigh = 0; altEntry = 0;
    @(negedge clk);
  endtask

  // Transmit byte d, expecting period P; host pulls low in [pFrom,pTo)
  task automatic sendTx(input logic [7:0] d, input int P, input int pFrom,
                        input int pTo, input string req);
    int bad = 0, pulses = 0, w = 0, firstBad = -1;
    while (!txReady && w < 2000) begin @(negedge clk); w++; end
    txData = d; txValid = 1;
    @(negedge clk);
    txValid = 0;
    for (int idx = 0; idx <= 10*P; idx++) begin
      int k;
      logic expLow;
      k = idx / P;
      expLow = (idx >= 10*P) ? 1'b0 : (k == 0) ? 1'b1 : (k == 9) ? 1'b0 : !d[k-1];
      if (lineDriveLow !== expLow) begin bad++; if (firstBad < 0) firstBad = idx; end
      if (rxValid || breakDetected) pulses++;
      hostLine = (idx >= pFrom && idx < pTo) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    hostLine = 1;
    check(bad == 0, req, firstBad, -1);
    if (pTo > pFrom) check(pulses == 0, "R7 receiver quiet during own transmit", pulses, 0);
  endtask

  // Drive a 10-bit frame (bit 0 first) and count receive pulses
  task automatic sendRx(input logic [9:0] bits, input int P, output int nValid,
                        output int nBrk, output logic [7:0] got, input bit probeTx);
    nValid = 0; nBrk = 0; got = 0;
    for (int idx = 0; idx < 11*P; idx++) begin
      hostLine = (idx < 10*P) ? bits[idx / P] : 1'b1;
      if (probeTx) txValid = (idx >= 2*P && idx < 7*P);
      @(negedge clk);
      if (rxValid) begin nValid++; got = rxData; end
      if (breakDetected) nBrk++;
      if (probeTx && idx == 5*P) begin
        check(!txReady && !lineDriveLow, "R8 no accept while receiving",
              {txReady, lineDriveLow}, 0);
      end
    end
    txValid = 0;
  endtask

  initial begin
    int nV, nB, id, bad, pulses, notReadyBad, firstBad;
    logic [7:0] got;
    doReset();

    // R10 reset state
    check(lineDriveLow == 0 && txReady == 1 && rxValid == 0 && breakDetected == 0,
          "R10 reset state", {lineDriveLow, txReady, rxValid, breakDetected}, 4'b0100);

    // R3 long period before mode entry
    sendTx(8'hA5, LP, 0, 0, "R3 period before mode entry");

    // R3/R4 every strap/entry combination, then a second strobe that must not matter
    for (int c = 0; c < 4; c++) begin
      int P;
      doReset();
      enterMode(c[0], c[1]);
      P = (c[0] || c[1]) ? LP : SP;
      sendTx(8'h3C, P, 0, 0, "R3 period chosen at mode entry");
      enterMode(!c[0], !c[1]);
      sendTx(8'hC3, P, 0, 0, "R4 later strobe ignored");
    end

    // Short period for the sweeps
    doReset();
    enterMode(0, 0);

    // R1 exhaustive transmit sweep
    for (int b = 0; b < 256; b++) sendTx(8'(b), SP, 0, 0, "R1 transmit frame timing");

    // R2 exhaustive receive sweep
    for (int b = 0; b < 256; b++) begin
      sendRx({1'b1, 8'(b), 1'b0}, SP, nV, nB, got, 1'b0);
      check(nV == 1 && nB == 0 && got == 8'(b), "R2 received byte", got, b);
    end

    // R8 transmit request held during reception is not taken
    sendRx({1'b1, 8'h5A, 1'b0}, SP, nV, nB, got, 1'b1);
    check(nV == 1 && got == 8'h5A, "R8 receive unaffected by txValid", got, 8'h5A);

    // R7 host activity during own transmit
    sendTx(8'hFF, SP, 2*SP, 4*SP, "R1 transmit with host pulse");

    // R9 framing error, then re-arm
    sendRx({1'b0, 8'h3C, 1'b0}, SP, nV, nB, got, 1'b0);
    check(nV == 0 && nB == 0, "R9 framing error dropped", nV + nB, 0);
    sendRx({1'b1, 8'h96, 1'b0}, SP, nV, nB, got, 1'b0);
    check(nV == 1 && got == 8'h96, "R9 re-armed after framing error", got, 8'h96);

    // R5/R6/R7/R8 break and its response
    id = -1; nV = 0; nB = 0; bad = 0; pulses = 0; notReadyBad = 0; firstBad = -1;
    for (int idx = 0; idx < 24*SP; idx++) begin
      if (idx < 10*SP) hostLine = 0;
      else if (id >= 0 && idx > id + SP && idx <= id + SP + 3) hostLine = 0;
      else hostLine = 1;
      @(negedge clk);
      if (id < 0) begin
        if (rxValid) nV++;
        if (breakDetected) begin nB++; id = idx; end
      end else begin
        logic expLow;
        if (rxValid || breakDetected) pulses++;
        if (idx <= id + 12*SP + 1) begin
          expLow = (idx > id + 2*SP) && (idx <= id + 12*SP);
          if (lineDriveLow !== expLow) begin bad++; if (firstBad < 0) firstBad = idx - id; end
          if (idx <= id + 12*SP && txReady) notReadyBad++;
        end
      end
    end
    hostLine = 1;
    check(nB == 1 && nV == 0, "R5 break flagged without byte", nV * 10 + nB, 1);
    check(id >= 9*SP && id < 10*SP, "R5 break detected in tenth bit", id, 9*SP + SP/2);
    check(bad == 0, "R6 break response shape", firstBad, -1);
    check(pulses == 0, "R7 receiver quiet during break response", pulses, 0);
    check(notReadyBad == 0, "R8 not ready during break response", notReadyBad, 0);

    // Port usable again afterwards
    repeat (4) @(negedge clk);
    sendRx({1'b1, 8'h81, 1'b0}, SP, nV, nB, got, 1'b0);
    check(nV == 1 && got == 8'h81, "R2 receive after break", got, 8'h81);
    check(txReady == 1, "R8 ready when idle", txReady, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule